// File: doc/BRIEF.md
# Capture/Compare Channel Flag Unit

This block is one channel hanging off a shared time-base counter. In compare mode it watches the counter and raises an interrupt flag when the counter lands on the programmed compare value. While the counter runs in a center-aligned pattern, the alignment setting and the current count direction decide whether a match counts. If the compare value lies above the period limit in a center-aligned pattern, the flag fires at the top of the count instead.

In capture mode a pin is passed through a synchronizer and an edge detector. An edge of the chosen polarity copies the live counter value into the channel register and raises the same flag. Software reaches the channel through a four-address byte port. The port holds an enable byte, a status byte and the two bytes of the channel register. The interrupt line is the flag gated by the enable bit.

Top module: `cc_channel`

## Requirements
- R1: Alignment 00 (edge mode), compare mode: a cycle with `cnt_tick_i`=1 and `cnt_i` equal to the channel register sets `flag_o` at the next clock edge.
- R2: Alignment 01: a compare match sets the flag only when `dir_down_i`=1.
- R3: Alignment 10: a compare match sets the flag only when `dir_down_i`=0.
- R4: Alignment 11: a compare match sets the flag in either direction.
- R5: In any alignment other than 00, when the channel register is greater than `period_i`, the flag is set on a tick where `cnt_i` equals `period_i`, in either direction, and never on the register value itself.
- R6: Capture mode (`capture_mode_i`=1): `pin_i` passes two synchronizer flops, then a previous-value flop. `fall_sel_i`=0 selects rising edges and 1 selects falling edges. A pin change made before clock edge 1 is acted on at edge 3. At that edge the channel register takes the `cnt_i` value present just before it, and the flag is set.
- R7: In compare mode the flag is set only in cycles with `cnt_tick_i`=1, so a counter value held over several cycles sets the flag once.
- R8: Writing status (address 1) with bit 1 = 0 clears the flag, and writing bit 1 = 1 has no effect. In capture mode, reading the low byte (address 3) also clears the flag. In compare mode that read leaves the flag unchanged.
- R9: If a flag set and a flag clear fall in the same cycle, the flag ends up set.
- R10: `irq_o` is high exactly when the flag is set and enable bit 1 (address 0) is 1.
- R11: Register map on `reg_addr_i`: 0 holds the enable in bit 1; 1 holds the flag in bit 1; 2 is the high byte of the channel register; 3 is the low byte. All other bits read 0. `reg_rdata_o` shows the addressed byte. Byte writes load the channel register in compare mode and are ignored in capture mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Time-base counter value |
| cnt_tick_i | input | 1 | Counter took a new value this cycle |
| dir_down_i | input | 1 | Counter counts down |
| align_i | input | 2 | Alignment mode (00 edge, 01/10/11 center) |
| period_i | input | CNT_W | Counter period limit |
| capture_mode_i | input | 1 | 1 = capture, 0 = compare |
| fall_sel_i | input | 1 | Capture polarity, 1 = falling |
| pin_i | input | 1 | Asynchronous capture pin |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of addressed byte |
| flag_o | output | 1 | Channel interrupt flag |
| irq_o | output | 1 | Flag gated by enable |
| ccr_o | output | CNT_W | Channel (compare/capture) register |

## Verification
The bench keeps the default 16-bit width and feeds a period of 9 with a tick every third cycle. Each counter value therefore persists over several clocks, which exposes repeated-set faults. A short period also reaches the turnaround points of the center pattern many times in a few hundred cycles, so every direction gate and the above-period case fire repeatedly. Capture edges are placed so that a clearing write meets a capture set in the same cycle.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    ALIGN_EDGE     = 2'b00,
    ALIGN_CTR_DN   = 2'b01,
    ALIGN_CTR_UP   = 2'b10,
    ALIGN_CTR_BOTH = 2'b11
  } align_e;

  localparam logic [1:0] ADDR_EN   = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;
  localparam logic [1:0] ADDR_LO   = 2'd3;
  localparam int         CH_BIT    = 1;
endpackage

// File: rtl/cc_sync_edge.sv
module cc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin_i;
        else             sync_q[i] <= sync_q[(i > 0) ? i - 1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[LAST];
  end

  assign edge_o = fall_sel_i ? (prev_q & ~sync_q[LAST]) : (~prev_q & sync_q[LAST]);

  AST_RISE_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && !fall_sel_i) |=> !(edge_o && !fall_sel_i)); // R6
endmodule

// File: rtl/cc_match.sv
module cc_match
  import cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             dir_down_i,
  input  logic [1:0]       align_i,
  output logic             hit_o
);
  logic eq, over, dir_ok;

  assign eq   = (cnt_i == cmp_i);
  assign over = (align_i != ALIGN_EDGE) && (cmp_i > period_i);

  always_comb begin
    unique case (align_i)
      ALIGN_CTR_DN: dir_ok = dir_down_i;
      ALIGN_CTR_UP: dir_ok = ~dir_down_i;
      default:      dir_ok = 1'b1;
    endcase
  end

  // above-period compare fires at the turnaround regardless of direction
  assign hit_o = tick_i & (over ? (cnt_i == period_i) : (eq & dir_ok));
endmodule

// File: rtl/cc_regif.sv
module cc_regif
  import cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_mode_i,
  input  logic             set_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic             flag_o,
  output logic             en_o,
  output logic             clr_o,
  output logic [CNT_W-1:0] ccr_o
);
  localparam int EXT_W = 16;

  logic             flag_q, en_q;
  logic [CNT_W-1:0] ccr_q;
  logic [EXT_W-1:0] ccr_ext;

  assign ccr_ext = EXT_W'(ccr_q);

  assign clr_o = (reg_wr_i && reg_addr_i == ADDR_STAT && !reg_wdata_i[CH_BIT])
              || (reg_rd_i && reg_addr_i == ADDR_LO && capture_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
    end else if (clr_o) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else if (reg_wr_i && reg_addr_i == ADDR_EN) en_q <= reg_wdata_i[CH_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccr_q <= '0;
    end else if (capture_mode_i) begin
      if (cap_i) ccr_q <= cnt_i;
    end else if (reg_wr_i && reg_addr_i == ADDR_HI) begin
      ccr_q <= CNT_W'({reg_wdata_i, ccr_ext[7:0]});
    end else if (reg_wr_i && reg_addr_i == ADDR_LO) begin
      ccr_q <= CNT_W'({ccr_ext[EXT_W-1:8], reg_wdata_i});
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_EN:   reg_rdata_o[CH_BIT] = en_q;
      ADDR_STAT: reg_rdata_o[CH_BIT] = flag_q;
      ADDR_HI:   reg_rdata_o = ccr_ext[EXT_W-1:8];
      default:   reg_rdata_o = ccr_ext[7:0];
    endcase
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign ccr_o  = ccr_q;
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_tick_i,
  input  logic             dir_down_i,
  input  logic [1:0]       align_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             capture_mode_i,
  input  logic             fall_sel_i,
  input  logic             pin_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] ccr_o
);
  logic cap_edge, cmp_hit, set_pulse, flag_clr, en;

  cc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .fall_sel_i (fall_sel_i),
    .edge_o     (cap_edge)
  );

  cc_match #(.CNT_W(CNT_W)) u_match (
    .tick_i     (cnt_tick_i),
    .cnt_i      (cnt_i),
    .cmp_i      (ccr_o),
    .period_i   (period_i),
    .dir_down_i (dir_down_i),
    .align_i    (align_i),
    .hit_o      (cmp_hit)
  );

  assign set_pulse = capture_mode_i ? cap_edge : cmp_hit;

  cc_regif #(.CNT_W(CNT_W)) u_regif (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .capture_mode_i (capture_mode_i),
    .set_i          (set_pulse),
    .cap_i          (cap_edge),
    .cnt_i          (cnt_i),
    .reg_wr_i       (reg_wr_i),
    .reg_rd_i       (reg_rd_i),
    .reg_addr_i     (reg_addr_i),
    .reg_wdata_i    (reg_wdata_i),
    .reg_rdata_o    (reg_rdata_o),
    .flag_o         (flag_o),
    .en_o           (en),
    .clr_o          (flag_clr),
    .ccr_o          (ccr_o)
  );

  assign irq_o = flag_o & en;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_pulse |=> flag_o); // R9
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr && !set_pulse) |=> !flag_o); // R8
  AST_CAPT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_mode_i && cap_edge) |=> (ccr_o == $past(cnt_i))); // R6
  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_mode_i && !cnt_tick_i && !flag_clr) |=> $stable(flag_o)); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o); // R10
endmodule

// File: tb/tb_cc_channel.sv
module tb_cc_channel;
  localparam int W = 16;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] cnt = '0, period = 16'd9;
  logic         tick = 0, dir_dn = 0, cap = 0, fsel = 0, pin = 0;
  logic [1:0]   align = 2'b00, addr = 2'd0;
  logic         wr = 0, rd = 0;
  logic [7:0]   wdata = 8'h00, rdata;
  logic         flag, irq;
  logic [W-1:0] ccr;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R11";

  cc_channel dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_tick_i(tick), .dir_down_i(dir_dn),
    .align_i(align), .period_i(period), .capture_mode_i(cap), .fall_sel_i(fsel),
    .pin_i(pin), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .flag_o(flag), .irq_o(irq), .ccr_o(ccr)
  );

  always #5 clk = ~clk;

  // reference model
  logic         m_flag = 0, m_en = 0;
  logic [W-1:0] m_ccr = '0;
  logic         s1 = 0, s2 = 0, prv = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0; m_en = 0; m_ccr = '0; s1 = 0; s2 = 0; prv = 0;
    end else begin
      logic edg, set, clr;
      edg = fsel ? (prv && !s2) : (!prv && s2);
      set = 0;
      if (cap) set = edg;
      else if (tick) begin
        if (align != 2'b00 && m_ccr > period) set = (cnt == period);
        else if (cnt == m_ccr)
          case (align)
            2'b01:   set = dir_dn;
            2'b10:   set = !dir_dn;
            default: set = 1;
          endcase
      end
      clr = (wr && addr == 2'd1 && !wdata[1]) || (rd && addr == 2'd3 && cap);
      if (set) m_flag = 1; else if (clr) m_flag = 0;
      if (wr && addr == 2'd0) m_en = wdata[1];
      if (cap) begin
        if (edg) m_ccr = cnt;
      end else if (wr && addr == 2'd2) m_ccr[15:8] = wdata;
      else if (wr && addr == 2'd3) m_ccr[7:0] = wdata;
      prv = s2; s2 = s1; s1 = pin;
    end
  end

  function automatic logic [7:0] exp_rdata();
    case (addr)
      2'd0:    return {6'b0, m_en, 1'b0};
      2'd1:    return {6'b0, m_flag, 1'b0};
      2'd2:    return m_ccr[15:8];
      default: return m_ccr[7:0];
    endcase
  endfunction

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("flag", 16'(flag), 16'(m_flag));
      chk("irq", 16'(irq), 16'(m_flag & m_en));   // R10
      chk("ccr", ccr, m_ccr);
      chk("rdata", 16'(rdata), 16'(exp_rdata())); // R11
    end
  end

  // counter generator
  bit run = 0;
  int pc = 0;
  localparam int PRESC = 3;

  task automatic step();
    @(negedge clk);
    wr = 0; rd = 0; tick = 0;
    if (run) begin
      pc++;
      if (pc >= PRESC) begin
        pc = 0; tick = 1;
        if (align == 2'b00) begin
          dir_dn = 0; cnt = (cnt >= period) ? '0 : cnt + 1'b1;
        end else if (!dir_dn) begin
          if (cnt >= period) begin dir_dn = 1; cnt = cnt - 1'b1; end
          else cnt = cnt + 1'b1;
        end else begin
          if (cnt == 0) begin dir_dn = 0; cnt = cnt + 1'b1; end
          else cnt = cnt - 1'b1;
        end
      end
    end
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    step(); wr = 1; addr = a; wdata = d;
  endtask

  task automatic rreg(logic [1:0] a);
    step(); rd = 1; addr = a;
  endtask

  task automatic run_with_clears(int n);
    for (int i = 0; i < n; i++) begin
      if (i % 17 == 16) wreg(2'd1, 8'h00); else step();
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R11";   // reset state
    chk("reset flag", 16'(flag), 16'd0);
    chk("reset irq", 16'(irq), 16'd0);
    chk("reset ccr", ccr, 16'd0);

    // R11 / R10: enable and compare value
    wreg(2'd0, 8'h02);
    wreg(2'd2, 8'h00);
    wreg(2'd3, 8'h05);
    rreg(2'd2); rreg(2'd0);

    // R1 / R7: edge mode, prescaled ticks
    cur_req = "R1"; align = 2'b00; run = 1;
    steps(60);
    cur_req = "R8";
    rreg(2'd3);          // compare-mode read: no clear
    wreg(2'd1, 8'hFF);   // writing 1: no effect
    wreg(2'd1, 8'hFD);   // clear
    cur_req = "R7"; steps(40);
    wreg(2'd1, 8'h00);
    wreg(2'd0, 8'h00);   // R10 irq masked
    cur_req = "R10"; steps(40);
    wreg(2'd0, 8'h02);

    // R2 / R3 / R4 center modes
    wreg(2'd3, 8'h04);
    cur_req = "R2"; align = 2'b01; run_with_clears(150);
    cur_req = "R3"; align = 2'b10; run_with_clears(150);
    cur_req = "R4"; align = 2'b11; run_with_clears(150);

    // R5: compare above period
    wreg(2'd3, 8'h14);
    cur_req = "R5"; align = 2'b11; run_with_clears(150);
    align = 2'b01; run_with_clears(100);
    align = 2'b00; run_with_clears(80);  // edge mode: 20 never matched

    // R6: capture rising
    cur_req = "R6"; wreg(2'd1, 8'h00);
    step(); cap = 1; fsel = 0;
    steps(10); step(); pin = 1; steps(8);
    cur_req = "R8"; rreg(2'd3);          // capture-mode read clears
    steps(5);
    cur_req = "R11"; wreg(2'd3, 8'hAA); wreg(2'd2, 8'h55); steps(3); // ignored
    cur_req = "R6"; step(); pin = 0; steps(10);  // falling ignored
    step(); fsel = 1; steps(4);
    step(); pin = 1; steps(8);
    step(); pin = 0; steps(8);           // falling captured
    rreg(2'd3); steps(4);

    // R9: set and clear collide
    cur_req = "R9";
    step(); pin = 1; steps(6);
    step(); pin = 0; step(); wreg(2'd1, 8'h00);
    steps(6);
    rreg(2'd1); steps(4);

    run = 0; steps(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule